// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit with Trap

This unit performs addition or subtraction on 32-bit tagged integers, the representation used by dynamically typed language runtimes in which the two least significant bits of a word mark it as a small integer (both zero) or as some other kind of object. A single control input chooses between adding and subtracting. The arithmetic result leaves the unit combinationally in the same cycle as the operands. A four-bit condition-code register (negative, zero, overflow, carry) sits behind it and captures new flags on the next clock edge.

When an operand carries a nonzero tag, or when the signed result does not fit in 32 bits, the unit raises a tag-overflow trap instead of just setting a flag. On a trap the condition-code write is suppressed and the flag register keeps its previous contents. The result bus is still driven during a trap, but the consumer must discard it.

Operands arrive with a valid qualifier. There is no back-pressure: the unit accepts a new operand pair on every cycle that `in_valid` is high, so it has no ready output. A cycle with `in_valid` low is a bubble. It raises no trap and leaves the flags untouched. Exception dispatch, the register file and wide (64-bit) condition codes live outside this block.

Top module: `tagalu_unit`

## Requirements
- R1: `res` equals `in_a + in_b` modulo 2^32 when `in_op` is 0 (add), and `in_a - in_b` modulo 2^32 when `in_op` is 1 (subtract). It is driven in the same cycle, whether or not a trap occurs.
- R2: With `in_valid` high, `trap` is 1 whenever bit 0 or bit 1 of either operand is set.
- R3: With `in_valid` high and `in_op` 0, `trap` is 1 when both operands have the same bit 31 and `res` bit 31 differs from it (signed add overflow).
- R4: With `in_valid` high and `in_op` 1, `trap` is 1 when the operands differ in bit 31 and `res` bit 31 differs from `in_a` bit 31 (signed subtract overflow).
- R5: `cc_we` is 1 exactly when `in_valid` is high and `trap` is 0. With `in_valid` low, both `trap` and `cc_we` are 0.
- R6: After a clock edge at which `cc_we` was 1, `cc_n` equals result bit 31, `cc_z` is 1 if and only if the result was zero, and `cc_v` is 0.
- R7: After a clock edge at which `cc_we` was 1, `cc_c` is 1 for an add when the result is unsigned-less-than `in_a`, and for a subtract when `in_a` is unsigned-less-than `in_b`.
- R8: After a clock edge at which `cc_we` was 0 (a trap or a bubble), all four flags keep their previous values.
- R9: A clock edge with `rst` high clears all four flags to 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| in_valid | input | 1 | Operand pair is present this cycle |
| in_op | input | 1 | 0 = add, 1 = subtract |
| in_a | input | 32 | First operand (minuend for subtract) |
| in_b | input | 32 | Second operand (subtrahend for subtract) |
| res | output | 32 | Arithmetic result, combinational |
| trap | output | 1 | Tag-overflow trap, combinational |
| cc_we | output | 1 | Flag write strobe for this cycle |
| cc_n | output | 1 | Registered negative flag |
| cc_z | output | 1 | Registered zero flag |
| cc_v | output | 1 | Registered overflow flag |
| cc_c | output | 1 | Registered carry flag |

## Verification
The bound checker checks every cycle that a nonzero tag or a sign-detected overflow raises `trap`. It also checks that `trap` and `cc_we` are never high together, that bubbles stay silent, that flags hold whenever no write happens, that a write leaves `cc_v` clear and `cc_n` equal to the prior result sign, and that reset clears the register. The exact result values, the carry rule for each operation, the zero flag on wrap-around, and the flags surviving a trap that follows a real write can only be shown by the bench. It does this with a vector table and with directed bubble and mid-run reset cases.

// File: rtl/tagalu_pkg.sv
package tagalu_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } tag_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

endpackage

// File: rtl/tagalu_arith.sv
module tagalu_arith
  import tagalu_pkg::*;
#(
  parameter int W = 32
) (
  input  tag_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   sum,
  output logic           ovf,
  output logic           carry
);
  localparam int MSB = W - 1;

  logic [W-1:0] sign_mix;

  always_comb begin
    if (op == OP_SUB) begin
      sum      = a - b;
      sign_mix = (a ^ b) & (a ^ sum);
      carry    = (a < b);
    end else begin
      sum      = a + b;
      sign_mix = ~(a ^ b) & (a ^ sum);
      carry    = (sum < a);
    end
    ovf = sign_mix[MSB];
  end

endmodule

// File: rtl/tagalu_tagchk.sv
module tagalu_tagchk #(
  parameter int W  = 32,
  parameter int TB = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         bad
);
  logic [TB-1:0] tag_or;

  generate
    for (genvar i = 0; i < TB; i++) begin : g_tag
      assign tag_or[i] = a[i] | b[i];
    end
  endgenerate

  assign bad = |tag_or;

endmodule

// File: rtl/tagalu_ccreg.sv
module tagalu_ccreg
  import tagalu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  cc_t  d,
  output cc_t  q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      q <= d;
    end
  end

endmodule

// File: rtl/tagalu_unit.sv
module tagalu_unit
  import tagalu_pkg::*;
#(
  parameter int W  = 32,
  parameter int TB = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] res,
  output logic         trap,
  output logic         cc_we,
  output logic         cc_n,
  output logic         cc_z,
  output logic         cc_v,
  output logic         cc_c
);
  localparam int MSB = W - 1;

  tag_op_e op_sel;
  logic    ovf;
  logic    carry;
  logic    tag_bad;
  cc_t     cc_next;
  cc_t     cc_q;

  assign op_sel = tag_op_e'(in_op);

  tagalu_arith #(.W(W)) u_arith (
    .op    (op_sel),
    .a     (in_a),
    .b     (in_b),
    .sum   (res),
    .ovf   (ovf),
    .carry (carry)
  );

  tagalu_tagchk #(.W(W), .TB(TB)) u_tag (
    .a   (in_a),
    .b   (in_b),
    .bad (tag_bad)
  );

  // A trap and a flag write are mutually exclusive; a bubble yields neither.
  assign trap  = in_valid & (tag_bad | ovf);
  assign cc_we = in_valid & ~(tag_bad | ovf);

  always_comb begin
    cc_next.n = res[MSB];
    cc_next.z = (res == '0);
    cc_next.v = ovf;
    cc_next.c = carry;
  end

  tagalu_ccreg u_cc (
    .clk (clk),
    .rst (rst),
    .we  (cc_we),
    .d   (cc_next),
    .q   (cc_q)
  );

  assign cc_n = cc_q.n;
  assign cc_z = cc_q.z;
  assign cc_v = cc_q.v;
  assign cc_c = cc_q.c;

endmodule

// File: rtl/tagalu_checker.sv
module tagalu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_op,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [W-1:0] res,
  input logic         trap,
  input logic         cc_we,
  input logic         cc_n,
  input logic         cc_z,
  input logic         cc_v,
  input logic         cc_c
);
  localparam int MSB = W - 1;

  logic [3:0] flags;
  assign flags = {cc_n, cc_z, cc_v, cc_c};

  // R2
  p_tag_trap_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_a[1:0] != 2'b00 || in_b[1:0] != 2'b00)) |-> trap);

  // R3
  p_add_ovf_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_op && in_a[MSB] == in_b[MSB] && res[MSB] != in_a[MSB]) |-> trap);

  // R4
  p_sub_ovf_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op && in_a[MSB] != in_b[MSB] && res[MSB] != in_a[MSB]) |-> trap);

  // R5
  p_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(trap && cc_we));

  p_bubble_r5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (!trap && !cc_we));

  // R6
  p_v_clear_r6: assert property (@(posedge clk) disable iff (rst)
    cc_we |=> !cc_v);

  p_n_sign_r6: assert property (@(posedge clk) disable iff (rst)
    cc_we |=> (cc_n == $past(res[MSB])));

  // R8
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cc_we |=> $stable(flags));

  // R9
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (flags == 4'b0000));

endmodule

bind tagalu_unit tagalu_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_op    (in_op),
  .in_a     (in_a),
  .in_b     (in_b),
  .res      (res),
  .trap     (trap),
  .cc_we    (cc_we),
  .cc_n     (cc_n),
  .cc_z     (cc_z),
  .cc_v     (cc_v),
  .cc_c     (cc_c)
);

// File: tb/tagalu_unit_bench.sv
module tagalu_unit_bench;

  localparam int W    = 32;
  localparam int NVEC = 14;

  // {op, a, b, expected trap}
  localparam logic [65:0] VEC [0:NVEC-1] = '{
    {1'b0, 32'h0000_0004, 32'h0000_0008, 1'b0},
    {1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0},
    {1'b0, 32'hFFFF_FFFC, 32'h0000_0004, 1'b0},
    {1'b0, 32'h0000_0001, 32'h0000_0004, 1'b1},
    {1'b0, 32'h0000_0004, 32'h0000_0002, 1'b1},
    {1'b0, 32'h7FFF_FFFC, 32'h0000_0004, 1'b1},
    {1'b0, 32'h8000_0000, 32'h8000_0000, 1'b1},
    {1'b1, 32'h0000_0008, 32'h0000_0004, 1'b0},
    {1'b1, 32'h0000_0004, 32'h0000_0008, 1'b0},
    {1'b1, 32'h8000_0000, 32'h0000_0004, 1'b1},
    {1'b1, 32'h7FFF_FFFC, 32'hFFFF_FFFC, 1'b1},
    {1'b1, 32'h0000_0010, 32'h0000_0010, 1'b0},
    {1'b1, 32'h0000_0003, 32'h0000_0000, 1'b1},
    {1'b0, 32'hFFFF_FFF8, 32'hFFFF_FFF8, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_op = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic [W-1:0] res;
  logic         trap;
  logic         cc_we;
  logic         cc_n, cc_z, cc_v, cc_c;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] exp_cc = 4'b0000;

  always #2ns clk = ~clk;

  tagalu_unit u_tagalu_unit (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_op    (in_op),
    .in_a     (in_a),
    .in_b     (in_b),
    .res      (res),
    .trap     (trap),
    .cc_we    (cc_we),
    .cc_n     (cc_n),
    .cc_z     (cc_z),
    .cc_v     (cc_v),
    .cc_c     (cc_c)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_res(input logic op, input logic [W-1:0] a, input logic [W-1:0] b);
    return op ? (a - b) : (a + b);
  endfunction

  function automatic logic [3:0] model_cc(input logic op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    logic c;
    r = model_res(op, a, b);
    c = op ? (a < b) : (r < a);
    return {r[W-1], (r == '0), 1'b0, c};
  endfunction

  function automatic logic [3:0] flags();
    return {cc_n, cc_z, cc_v, cc_c};
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400us;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1ns;
    chk("R9 reset state", {28'd0, flags()}, 32'd0);

    // Vector table: R1 result, R2/R3/R4 trap, R5 strobe, R6/R7/R8 flags
    for (int i = 0; i < NVEC; i++) begin
      logic vop, vtrap;
      logic [W-1:0] va, vb;
      {vop, va, vb, vtrap} = VEC[i];
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = vop;
      in_a     = va;
      in_b     = vb;
      #1ns;
      chk("R1 result", res, model_res(vop, va, vb));
      chk("R2/R3/R4 trap", {31'd0, trap}, {31'd0, vtrap});
      chk("R5 write strobe", {31'd0, cc_we}, {31'd0, ~vtrap});
      if (!vtrap) exp_cc = model_cc(vop, va, vb);
      @(posedge clk);
      #1ns;
      chk(vtrap ? "R8 flags held on trap" : "R6/R7 flags written",
          {28'd0, flags()}, {28'd0, exp_cc});
    end

    // Set known nonzero flags: 4 - 8 gives N=1, C=1
    @(negedge clk);
    in_valid = 1'b1; in_op = 1'b1; in_a = 32'h4; in_b = 32'h8;
    exp_cc = 4'b1001;
    @(posedge clk); #1ns;
    chk("R7 subtract borrow", {28'd0, flags()}, {28'd0, exp_cc});

    // Bubble with bad tags and overflowing operands: silent, flags held
    @(negedge clk);
    in_valid = 1'b0; in_op = 1'b0; in_a = 32'h7FFF_FFFF; in_b = 32'h0000_0003;
    #1ns;
    chk("R5 bubble no trap", {31'd0, trap}, 32'd0);
    chk("R5 bubble no strobe", {31'd0, cc_we}, 32'd0);
    chk("R1 result driven on bubble", res, 32'h8000_0002);
    @(posedge clk); #1ns;
    chk("R8 flags held on bubble", {28'd0, flags()}, {28'd0, exp_cc});

    // Trap after a real write: flags survive
    @(negedge clk);
    in_valid = 1'b1; in_op = 1'b0; in_a = 32'h0000_0010; in_b = 32'h0000_0001;
    #1ns;
    chk("R2 tag trap", {31'd0, trap}, 32'd1);
    chk("R1 result driven on trap", res, 32'h0000_0011);
    @(posedge clk); #1ns;
    chk("R8 flags held after trap", {28'd0, flags()}, {28'd0, exp_cc});

    // Reset mid-run with a writing operation present
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_op = 1'b1; in_a = 32'h4; in_b = 32'h8;
    @(posedge clk); #1ns;
    chk("R9 reset overrides write", {28'd0, flags()}, 32'd0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1ns;
    chk("R9 flags stay cleared", {28'd0, flags()}, 32'd0);

    finish_run();
  end

endmodule